// File: doc/BRIEF.md
# ECC-Protected Multi-Port SRAM Burst Controller

This block sits between several inbound request ports and a 256-bit wide on-chip SRAM array. Each port presents a request with a byte address, a byte count, a write flag, write data and a per-lane write mask. A request is accepted only when its address falls inside a window set by a base value and an upper bound. A fixed-priority arbiter accepts one such request at a time, and that request holds the controller until its last beat has been delivered.

Beside every 32-bit lane the array stores a 7-bit single-error-correct, double-error-detect code. Writes compute each enabled lane's code directly from the new data, so an aligned lane store never reads the array first. Reads issue one array access per cycle, moving the address by a fixed stride of 16. Reads continue until the byte count is used up. Each returned word is decoded lane by lane, and the data goes back to the requesting port together with correctable and uncorrectable flags. Checking stays off after reset until a configuration write turns it on. The address of the last flagged beat is held in a status output.

Top module: `ecc_sram_ctrl`

## Requirements
- R1: A request is accepted (`req_ack` high for one cycle) only when `win_base <= req_addr < win_upper`; a request outside that range is never accepted and causes no array access and no response.
- R2: When several ports hold in-window requests in an idle cycle, the lowest-numbered port is accepted first.
- R3: While a transaction is in progress no other port is accepted; the next acceptance comes no earlier than the cycle in which the previous transaction's last response beat is valid.
- R4: A write makes exactly one array access, with `mem_we` high and `mem_lane_we` equal to the request's `req_lane_en`. It never makes a read access, so lanes whose enable bit is 0 keep their old data and codes.
- R5: A read of N bytes makes ceil(N/16) array accesses on consecutive cycles, starting at `req_addr` with the address rising by 16 per access. Each access returns one beat to the requesting port, in order, with only that port's `rsp_valid` bit set.
- R6: The code of lane i sits at `mem_wcode[7i+6:7i]` and covers `mem_wdata[32i+31:32i]`. Its bits [5:0] form a Hamming syndrome base: data bit k is placed at the k-th codeword position from 1 to 38 that is not a power of two, and check bit b is the XOR of the data bits whose position has bit b set. Bit 6 is the XOR of all 32 data bits and the six check bits.
- R7: After reset, checking is off. Read data is then returned unchanged, `rsp_ce` and `rsp_ue` stay 0, and `err_addr` is not updated. A cycle with `cfg_we` high loads `cfg_chk_en` into the enable.
- R8: With checking on, a lane with one flipped data bit is returned corrected, and `rsp_ce` is raised with that beat.
- R9: With checking on, a lane with two flipped bits raises `rsp_ue` and is returned uncorrected. This includes an unwritten array word, which holds zero data and the code 7'h03 in every lane.
- R10: `err_addr` is 0 after reset. It captures the array address of every beat returned with `rsp_ce` or `rsp_ue` set, in the same cycle that the beat is valid.
- R11: An accepted read's first access is in the cycle after `req_ack`, and each beat's `rsp_valid` comes two cycles after its access. For a single-beat read that is three cycles after `req_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Load strobe for the check enable |
| cfg_chk_en | input | 1 | Check enable value loaded by `cfg_we` |
| win_base | input | AW | Lowest accepted byte address |
| win_upper | input | AW | First byte address above the window |
| req_valid | input | NPORT | Per-port request valid |
| req_write | input | NPORT | Per-port write flag |
| req_addr | input | NPORT*AW | Per-port byte address |
| req_bytes | input | NPORT*CW | Per-port read byte count (at least 1) |
| req_wdata | input | NPORT*DW | Per-port write data |
| req_lane_en | input | NPORT*LANES | Per-port lane write enables |
| req_ack | output | NPORT | One-cycle acceptance pulse per port |
| rsp_valid | output | NPORT | Response beat valid, one bit per port |
| rsp_data | output | DW | Response data (corrected when checking is on) |
| rsp_ce | output | 1 | A lane of this beat was corrected |
| rsp_ue | output | 1 | A lane of this beat is uncorrectable |
| err_addr | output | AW | Array address of the last flagged beat |
| mem_en | output | 1 | Array access strobe |
| mem_we | output | 1 | Array write |
| mem_lane_we | output | LANES | Array lane write enables |
| mem_addr | output | AW | Array byte address |
| mem_wdata | output | DW | Array write data |
| mem_wcode | output | LANES*7 | Array write check codes |
| mem_rdata | input | DW | Array read data, one cycle after the access |
| mem_rcode | input | LANES*7 | Array read check codes, one cycle after the access |

## Verification
The bench reads unwritten words both before and after checking is turned on. A design that reports errors while checking is off, or that takes zeroed memory as clean, fails one of those two reads. It flips one bit in one word and two bits of the same lane in another. A decoder that mixes up the two parity cases returns wrong data or the wrong flag. It also writes a single lane over a full word and counts array reads, which catches a hidden read-modify-write or a mask that clobbers neighbours. Finally it presents an address equal to the upper bound and two ports at once. That exposes an inclusive window compare, inverted priority, or a grant handed over before the burst has drained.

// File: rtl/ecc_sram_pkg.sv
package ecc_sram_pkg;
  localparam int LANE_W = 32;
  localparam int CODE_W = 7;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} ctl_state_e;

  // Hamming check bits: data bit i lives at the i-th non-power-of-two position.
  function automatic logic [5:0] lane_hbits(input logic [LANE_W-1:0] d);
    logic [5:0] h;
    int unsigned pos;
    h = '0;
    pos = 3;
    for (int i = 0; i < LANE_W; i++) begin
      if (d[i]) h ^= pos[5:0];
      pos++;
      if ((pos & (pos - 1)) == 0) pos++;
    end
    return h;
  endfunction

  // Mask with the data bit whose codeword position equals the syndrome.
  function automatic logic [LANE_W-1:0] lane_flip(input logic [5:0] syn);
    logic [LANE_W-1:0] m;
    int unsigned pos;
    m = '0;
    pos = 3;
    for (int i = 0; i < LANE_W; i++) begin
      if (pos[5:0] == syn) m[i] = 1'b1;
      pos++;
      if ((pos & (pos - 1)) == 0) pos++;
    end
    return m;
  endfunction

  function automatic logic [CODE_W-1:0] lane_encode(input logic [LANE_W-1:0] d);
    logic [5:0] h;
    h = lane_hbits(d);
    return {(^d) ^ (^h), h};
  endfunction
endpackage

// File: rtl/ecc_sram_window.sv
module ecc_sram_window #(
  parameter int NPORT = 2,
  parameter int AW    = 20
) (
  input  logic [NPORT-1:0]    req_valid,
  input  logic [NPORT*AW-1:0] req_addr,
  input  logic [AW-1:0]       win_base,
  input  logic [AW-1:0]       win_upper,
  output logic [NPORT-1:0]    claim
);
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [AW-1:0] a;
    assign a        = req_addr[p*AW +: AW];
    assign claim[p] = req_valid[p] && (a >= win_base) && (a < win_upper);
  end
endmodule

// File: rtl/ecc_sram_arb.sv
module ecc_sram_arb #(
  parameter  int NPORT = 2,
  localparam int IW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [NPORT-1:0] claim,
  output logic [NPORT-1:0] ack,
  output logic [IW-1:0]    idx,
  output logic             any
);
  always_comb begin
    ack = '0;
    idx = '0;
    any = |claim;
    for (int i = NPORT - 1; i >= 0; i--) begin
      if (claim[i]) idx = IW'(i);
    end
    if (en && any) ack[idx] = 1'b1;
  end

  // R2: an accepted port never has a lower-numbered port also claiming
  assert_fixed_prio_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack != '0) |-> ($onehot(ack) && ((claim & (ack - NPORT'(1))) == '0)));
endmodule

// File: rtl/ecc_sram_lane_chk.sv
module ecc_sram_lane_chk
  import ecc_sram_pkg::*;
(
  input  logic              chk_en,
  input  logic [LANE_W-1:0] rd_data,
  input  logic [CODE_W-1:0] rd_code,
  output logic [LANE_W-1:0] fix_data,
  output logic              ce,
  output logic              ue
);
  logic [5:0] syn;
  logic       par_err;

  always_comb begin
    syn      = rd_code[5:0] ^ lane_hbits(rd_data);
    par_err  = ^{rd_data, rd_code};
    ce       = chk_en && par_err;
    ue       = chk_en && !par_err && (syn != '0);
    fix_data = ce ? (rd_data ^ lane_flip(syn)) : rd_data;
  end

  // R8: correction never touches more than one data bit
  always_comb begin
    assert_single_fix_R8: assert ($countones(fix_data ^ rd_data) <= 1);
  end
endmodule

// File: rtl/ecc_sram_ctrl.sv
module ecc_sram_ctrl
  import ecc_sram_pkg::*;
#(
  parameter  int NPORT  = 2,
  parameter  int AW     = 20,
  parameter  int CW     = 10,
  parameter  int DW     = 256,
  parameter  int STRIDE = 16,
  localparam int LANES  = DW / LANE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic                  cfg_chk_en,
  input  logic [AW-1:0]         win_base,
  input  logic [AW-1:0]         win_upper,
  input  logic [NPORT-1:0]      req_valid,
  input  logic [NPORT-1:0]      req_write,
  input  logic [NPORT*AW-1:0]   req_addr,
  input  logic [NPORT*CW-1:0]   req_bytes,
  input  logic [NPORT*DW-1:0]   req_wdata,
  input  logic [NPORT*LANES-1:0] req_lane_en,
  output logic [NPORT-1:0]      req_ack,
  output logic [NPORT-1:0]      rsp_valid,
  output logic [DW-1:0]         rsp_data,
  output logic                  rsp_ce,
  output logic                  rsp_ue,
  output logic [AW-1:0]         err_addr,
  output logic                  mem_en,
  output logic                  mem_we,
  output logic [LANES-1:0]      mem_lane_we,
  output logic [AW-1:0]         mem_addr,
  output logic [DW-1:0]         mem_wdata,
  output logic [LANES*CODE_W-1:0] mem_wcode,
  input  logic [DW-1:0]         mem_rdata,
  input  logic [LANES*CODE_W-1:0] mem_rcode
);
  localparam int IW = (NPORT > 1) ? $clog2(NPORT) : 1;

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // Control state
  ctl_state_e      state_q, state_d;
  logic [IW-1:0]   gnt_q, gnt_d;
  logic            wr_q, wr_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic [CW-1:0]   rem_q, rem_d;
  logic            rd_pend_q, rd_pend_d;
  logic [AW-1:0]   rd_addr_q;
  logic            chk_en_q;
  logic [DW-1:0]   wdata_q;
  logic [LANES-1:0] lane_en_q;

  logic [NPORT-1:0] claim;
  logic [IW-1:0]    win_idx;
  logic             any_claim;
  logic             load;

  ecc_sram_window #(.NPORT(NPORT), .AW(AW)) u_window (
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .win_base  (win_base),
    .win_upper (win_upper),
    .claim     (claim)
  );

  ecc_sram_arb #(.NPORT(NPORT)) u_arb (
    .clk   (clk),
    .rst_n (rst_i_n),
    .en    (state_q == ST_IDLE),
    .claim (claim),
    .ack   (req_ack),
    .idx   (win_idx),
    .any   (any_claim)
  );

  assign load = (state_q == ST_IDLE) && any_claim;

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    gnt_d     = gnt_q;
    wr_d      = wr_q;
    addr_d    = addr_q;
    rem_d     = rem_q;
    mem_en    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (any_claim) begin
          state_d = ST_RUN;
          gnt_d   = win_idx;
          wr_d    = req_write[win_idx];
          addr_d  = req_addr[win_idx*AW +: AW];
          rem_d   = req_bytes[win_idx*CW +: CW];
        end
      end
      ST_RUN: begin
        mem_en = 1'b1;
        if (wr_q) begin
          state_d = ST_IDLE;
        end else begin
          addr_d = addr_q + AW'(STRIDE);
          if (rem_q <= CW'(STRIDE)) begin
            rem_d   = '0;
            state_d = ST_DRAIN;
          end else begin
            rem_d = rem_q - CW'(STRIDE);
          end
        end
      end
      ST_DRAIN: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    rd_pend_d = mem_en && !wr_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q   <= ST_IDLE;
      gnt_q     <= '0;
      wr_q      <= 1'b0;
      addr_q    <= '0;
      rem_q     <= '0;
      rd_pend_q <= 1'b0;
      chk_en_q  <= 1'b0;
    end else begin
      state_q   <= state_d;
      gnt_q     <= gnt_d;
      wr_q      <= wr_d;
      addr_q    <= addr_d;
      rem_q     <= rem_d;
      rd_pend_q <= rd_pend_d;
      if (cfg_we) chk_en_q <= cfg_chk_en;
    end
  end

  // Wide write payload: no reset, loaded on acceptance only
  always_ff @(posedge clk) begin
    if (load) begin
      wdata_q   <= req_wdata[win_idx*DW +: DW];
      lane_en_q <= req_lane_en[win_idx*LANES +: LANES];
    end
    if (mem_en) rd_addr_q <= addr_q;
  end

  assign mem_we      = mem_en && wr_q;
  assign mem_lane_we = mem_we ? lane_en_q : '0;
  assign mem_addr    = addr_q;
  assign mem_wdata   = wdata_q;

  // Per-lane encode and check
  logic [DW-1:0]    fix_data;
  logic [LANES-1:0] lane_ce, lane_ue;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign mem_wcode[l*CODE_W +: CODE_W] = lane_encode(wdata_q[l*LANE_W +: LANE_W]);
    ecc_sram_lane_chk u_chk (
      .chk_en   (chk_en_q),
      .rd_data  (mem_rdata[l*LANE_W +: LANE_W]),
      .rd_code  (mem_rcode[l*CODE_W +: CODE_W]),
      .fix_data (fix_data[l*LANE_W +: LANE_W]),
      .ce       (lane_ce[l]),
      .ue       (lane_ue[l])
    );
  end

  // Response stage
  logic [NPORT-1:0] rsp_valid_d;
  logic [NPORT-1:0] rsp_valid_q;
  logic             rsp_ce_q, rsp_ue_q;
  logic [AW-1:0]    err_addr_q;
  logic [DW-1:0]    rsp_data_q;

  always_comb begin
    rsp_valid_d = '0;
    if (rd_pend_q) rsp_valid_d[gnt_q] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rsp_valid_q <= '0;
      rsp_ce_q    <= 1'b0;
      rsp_ue_q    <= 1'b0;
      err_addr_q  <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_ce_q    <= rd_pend_q && (|lane_ce);
      rsp_ue_q    <= rd_pend_q && (|lane_ue);
      if (rd_pend_q && ((|lane_ce) || (|lane_ue))) err_addr_q <= rd_addr_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_pend_q) rsp_data_q <= fix_data;
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign rsp_ce    = rsp_ce_q;
  assign rsp_ue    = rsp_ue_q;
  assign err_addr  = err_addr_q;

  // Assertions
  for (genvar p = 0; p < NPORT; p++) begin : g_win_chk
    assert_ack_in_window_R1: assert property (@(posedge clk) disable iff (!rst_i_n)
      req_ack[p] |-> ((req_addr[p*AW +: AW] >= win_base) && (req_addr[p*AW +: AW] < win_upper)));
  end

  assert_grant_held_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    ((state_q != ST_IDLE) && $past(state_q != ST_IDLE)) |-> $stable(gnt_q));

  assert_write_single_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mem_en && mem_we) |=> !mem_en);

  assert_burst_stride_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mem_en && !mem_we && $past(mem_en && !mem_we)) |-> (mem_addr == $past(mem_addr) + AW'(STRIDE)));

  assert_rsp_onehot_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0(rsp_valid));

  assert_chk_off_quiet_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    !chk_en_q |=> !(rsp_ce || rsp_ue));

  assert_err_capture_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    ((rsp_valid != '0) && (rsp_ce || rsp_ue)) |-> (err_addr == $past(mem_addr, 2)));
endmodule

// File: tb/test_ecc_sram_ctrl.sv
module test_ecc_sram_ctrl;
  localparam int NP = 2, AW = 20, CW = 10, DW = 256, LN = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rst_n, cfg_we, cfg_chk_en;
  logic [AW-1:0]      win_base, win_upper;
  logic [NP-1:0]      req_valid, req_write, req_ack, rsp_valid;
  logic [NP*AW-1:0]   req_addr;
  logic [NP*CW-1:0]   req_bytes;
  logic [NP*DW-1:0]   req_wdata;
  logic [NP*LN-1:0]   req_lane_en;
  logic [DW-1:0]      rsp_data, mem_wdata, mem_rdata;
  logic               rsp_ce, rsp_ue, mem_en, mem_we;
  logic [AW-1:0]      err_addr, mem_addr;
  logic [LN-1:0]      mem_lane_we;
  logic [LN*7-1:0]    mem_wcode, mem_rcode;

  ecc_sram_ctrl #(.NPORT(NP), .AW(AW), .CW(CW), .DW(DW)) i_ecc_sram_ctrl (.*);

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Behavioural array: unwritten words read as zero data with code 7'h03 per lane
  logic [DW-1:0]   md [int];
  logic [LN*7-1:0] mc [int];
  logic [DW-1:0]   sh [int];
  int              inj [int];
  int rd_cnt = 0, wr_cnt = 0;

  always @(posedge clk) begin
    if (rst_n && mem_en) begin
      int w;
      logic [DW-1:0] d;
      logic [LN*7-1:0] c;
      w = int'(mem_addr >> 4);
      d = md.exists(w) ? md[w] : '0;
      c = mc.exists(w) ? mc[w] : {LN{7'h03}};
      if (mem_we) begin
        for (int l = 0; l < LN; l++) begin
          if (mem_lane_we[l]) begin
            d[32*l +: 32] = mem_wdata[32*l +: 32];
            c[7*l +: 7]   = mem_wcode[7*l +: 7];
          end
        end
        md[w] = d;
        mc[w] = c;
        wr_cnt++;
      end else begin
        mem_rdata <= d;
        mem_rcode <= c;
        rd_cnt++;
      end
    end
  end

  // Independent code model: build the codeword explicitly
  function automatic logic [6:0] ref_code(input logic [31:0] d);
    logic [38:1] cw;
    logic [5:0]  h;
    int k;
    cw = '0;
    k = 0;
    for (int p = 1; p <= 38; p++) if ((p & (p - 1)) != 0) begin cw[p] = d[k]; k++; end
    for (int b = 0; b < 6; b++) begin
      h[b] = 1'b0;
      for (int p = 1; p <= 38; p++) if (p[b]) h[b] ^= cw[p];
    end
    return {(^cw) ^ (^h), h};
  endfunction

  function automatic logic [DW-1:0] pat(input int seed);
    logic [DW-1:0] v;
    for (int l = 0; l < LN; l++) v[32*l +: 32] = seed * 32'h9E3779B1 + l * 32'h01010101;
    return v;
  endfunction

  typedef struct { int port; logic [DW-1:0] d; bit ce; bit ue; } item_t;
  item_t sb[$];
  bit    chk_on = 1'b0;
  string cur_req = "R7";
  int    ack_cyc [NP];
  int    last_rsp_cyc [NP];
  int    beats [NP];

  function automatic item_t exp_beat(input int p, input logic [AW-1:0] a);
    item_t it;
    int w;
    w = int'(a >> 4);
    it.port = p; it.ce = 1'b0; it.ue = 1'b0;
    if (!md.exists(w)) begin
      it.d = '0; it.ue = chk_on;
    end else if (inj.exists(w) && inj[w] == 1) begin
      it.d = chk_on ? sh[w] : md[w]; it.ce = chk_on;
    end else if (inj.exists(w) && inj[w] == 2) begin
      it.d = md[w]; it.ue = chk_on;
    end else begin
      it.d = sh[w];
    end
    return it;
  endfunction

  // Monitor: pop and compare each beat
  always @(negedge clk) begin
    if (rst_n && rsp_valid != '0) begin
      if (sb.size() == 0) begin
        chk(1'b0, cur_req, "unexpected beat", rsp_valid, '0);
      end else begin
        item_t it;
        it = sb.pop_front();
        chk(rsp_valid == NP'(1 << it.port), cur_req, "beat port", rsp_valid, NP'(1 << it.port));
        chk(rsp_data == it.d, cur_req, "beat data", rsp_data, it.d);
        chk({rsp_ce, rsp_ue} == {it.ce, it.ue}, cur_req, "beat flags {ce,ue}",
            {rsp_ce, rsp_ue}, {it.ce, it.ue});
        last_rsp_cyc[it.port] = cyc;
        beats[it.port]++;
      end
    end
  end

  // Driver: present a request, wait for acceptance, push expectations
  task automatic do_req(input int p, input bit wr, input logic [AW-1:0] a, input int nb,
                        input logic [DW-1:0] wd, input logic [LN-1:0] le);
    @(negedge clk);
    req_valid[p] = 1'b1;
    req_write[p] = wr;
    req_addr[p*AW +: AW] = a;
    req_bytes[p*CW +: CW] = CW'(nb);
    req_wdata[p*DW +: DW] = wd;
    req_lane_en[p*LN +: LN] = le;
    #1;
    while (!req_ack[p]) begin
      @(negedge clk);
      #1;
    end
    ack_cyc[p] = cyc;
    if (wr) begin
      int w;
      logic [DW-1:0] v;
      w = int'(a >> 4);
      v = sh.exists(w) ? sh[w] : '0;
      for (int l = 0; l < LN; l++) if (le[l]) v[32*l +: 32] = wd[32*l +: 32];
      sh[w] = v;
      if (inj.exists(w)) inj.delete(w);
    end else begin
      for (int off = 0; off < nb; off += 16) sb.push_back(exp_beat(p, a + AW'(off)));
    end
    @(negedge clk);
    req_valid[p] = 1'b0;
  endtask

  task automatic settle();
    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int r0, w0, bw;
    logic [DW-1:0] old;
    bit seen;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_chk_en = 1'b0;
    win_base = 20'h01000; win_upper = 20'h02000;
    req_valid = '0; req_write = '0; req_addr = '0; req_bytes = '0;
    req_wdata = '0; req_lane_en = '0;
    for (int i = 0; i < NP; i++) begin ack_cyc[i] = 0; last_rsp_cyc[i] = 0; beats[i] = 0; end
    repeat (5) @(negedge clk);
    chk(rsp_valid == '0, "R10", "rsp_valid in reset", rsp_valid, '0);
    chk(err_addr == '0, "R10", "err_addr in reset", err_addr, '0);
    chk(mem_en == 1'b0, "R4", "mem_en in reset", mem_en, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7: checking off, unwritten word at the window base comes back raw
    cur_req = "R7";
    do_req(0, 1'b0, 20'h01000, 16, '0, '0);
    settle();
    chk(err_addr == '0, "R7", "err_addr untouched while off", err_addr, '0);

    // R9/R10: checking on, unwritten word is uncorrectable
    @(negedge clk); cfg_we = 1'b1; cfg_chk_en = 1'b1;
    @(negedge clk); cfg_we = 1'b0; chk_on = 1'b1;
    cur_req = "R9";
    do_req(0, 1'b0, 20'h01010, 16, '0, '0);
    settle();
    chk(err_addr == 20'h01010, "R10", "err_addr after uninit read", err_addr, 20'h01010);

    // R4/R6: full-word writes, no array reads
    cur_req = "R4";
    r0 = rd_cnt; w0 = wr_cnt;
    do_req(1, 1'b1, 20'h01100, 0, pat(1), 8'hFF);
    do_req(1, 1'b1, 20'h01110, 0, pat(2), 8'hFF);
    do_req(1, 1'b1, 20'h01120, 0, pat(3), 8'hFF);
    settle();
    chk(rd_cnt == r0, "R4", "reads during writes", rd_cnt, r0);
    chk(wr_cnt == w0 + 3, "R4", "write accesses", wr_cnt, w0 + 3);
    for (int k = 0; k < 3; k++) begin
      logic [LN*7-1:0] ec;
      int w;
      w = 16'h0110 + k;
      for (int l = 0; l < LN; l++) ec[7*l +: 7] = ref_code(sh[w][32*l +: 32]);
      chk(mc[w] == ec, "R6", "stored lane codes", mc[w], ec);
    end

    // R5/R11: 40-byte burst gives three beats at stride 16
    cur_req = "R5";
    bw = beats[0]; r0 = rd_cnt;
    do_req(0, 1'b0, 20'h01100, 40, '0, '0);
    settle();
    chk(beats[0] - bw == 3, "R5", "beat count for 40 bytes", beats[0] - bw, 3);
    chk(rd_cnt - r0 == 3, "R5", "array reads for 40 bytes", rd_cnt - r0, 3);
    chk(last_rsp_cyc[0] - ack_cyc[0] == 5, "R11", "ack to last beat", last_rsp_cyc[0] - ack_cyc[0], 5);
    cur_req = "R11";
    do_req(0, 1'b0, 20'h01110, 16, '0, '0);
    settle();
    chk(last_rsp_cyc[0] - ack_cyc[0] == 3, "R11", "single-beat latency", last_rsp_cyc[0] - ack_cyc[0], 3);

    // R4: single-lane write leaves the other lanes alone
    cur_req = "R4";
    old = md[16'h0110];
    r0 = rd_cnt;
    do_req(1, 1'b1, 20'h01100, 0, pat(9), 8'h04);
    settle();
    chk(rd_cnt == r0, "R4", "reads during lane write", rd_cnt, r0);
    chk(md[16'h0110] == {old[255:96], pat(9)[95:64], old[63:0]}, "R4", "lane merge",
        md[16'h0110], {old[255:96], pat(9)[95:64], old[63:0]});
    do_req(0, 1'b0, 20'h01100, 16, '0, '0);
    settle();

    // R8: single flipped bit is corrected
    cur_req = "R8";
    md[16'h0111][77] = ~md[16'h0111][77];
    inj[16'h0111] = 1;
    do_req(0, 1'b0, 20'h01110, 16, '0, '0);
    settle();
    chk(err_addr == 20'h01110, "R10", "err_addr after correction", err_addr, 20'h01110);

    // R9: two flips in one lane are uncorrectable
    cur_req = "R9";
    md[16'h0112][3] = ~md[16'h0112][3];
    md[16'h0112][9] = ~md[16'h0112][9];
    inj[16'h0112] = 2;
    do_req(1, 1'b0, 20'h01120, 16, '0, '0);
    settle();

    // R1: at the upper bound and below the base nothing is accepted
    cur_req = "R1";
    r0 = rd_cnt; seen = 1'b0;
    @(negedge clk);
    req_valid[0] = 1'b1; req_write[0] = 1'b0; req_addr[0 +: AW] = 20'h02000; req_bytes[0 +: CW] = 16;
    for (int i = 0; i < 8; i++) begin #1; seen |= req_ack[0]; @(negedge clk); end
    req_addr[0 +: AW] = 20'h00FF0;
    for (int i = 0; i < 8; i++) begin #1; seen |= req_ack[0]; @(negedge clk); end
    req_valid[0] = 1'b0;
    repeat (4) @(negedge clk);
    chk(!seen, "R1", "ack outside window", seen, 0);
    chk(rd_cnt == r0, "R1", "array reads outside window", rd_cnt, r0);

    // R2/R3: simultaneous requests
    cur_req = "R2";
    fork
      do_req(0, 1'b0, 20'h01100, 64, '0, '0);
      do_req(1, 1'b0, 20'h01110, 16, '0, '0);
    join
    settle();
    chk(ack_cyc[0] < ack_cyc[1], "R2", "port 0 accepted first", ack_cyc[0], ack_cyc[1]);
    chk(ack_cyc[1] >= last_rsp_cyc[0], "R3", "port 1 waits for burst end", ack_cyc[1], last_rsp_cyc[0]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule